// File: doc/BRIEF.md
# SRAM Write-Readback Pattern Tester

This block exercises an external asynchronous SRAM without keeping any copy of the test data. It has two phases. In the write phase it walks every address once and stores the output of a maximal-length LFSR. When the last address has been written, it resets both the address counter and the LFSR to their starting values. It then starts a read phase that regenerates the same sequence and compares each stored word against it.

A full verify with no mismatch sends the tester back to a new write phase, so the loop runs for as long as it is clocked. The first mismatch moves it into a halt state. In that state the error flag is lit and the failing address stays on the address bus until reset.

The design advances in one of two ways. In free-run mode it moves on every clock. When free-run is off, it moves once per rising edge of a step input, so an operator can walk it through each bus cycle by hand. The SRAM strobes are active low. The data bus is shared, and the tester releases it whenever the SRAM output enable is asserted.

Top module: `sram_pattern_tester`

## Requirements
- R1: While and after reset, the address is 0, the data bus carries the seed 0x01, `sramWeN` and `sramOeN` are 1, `sramCeN` is 0, and `errFlag` and `readPhase` are 0.
- R2: In the write phase, each address receives the pattern value current at that address. After each write, both the address and the pattern advance by one step, giving 3 clocks per address.
- R3: The pattern advances as a right shift by one bit. When the bit shifted out is 1, the shifted value is XORed with 0xB8, which is the polynomial x^8+x^6+x^5+x^4+1. The seed is 0x01, so the sequence starts 0x01, 0xB8, 0x5C.
- R4: Once the last address (all ones) has been written, the address returns to 0 and the pattern returns to the seed. The read phase starts immediately after, with `readPhase`=1 at address 0.
- R5: In the read phase, each address takes 2 clocks: an address cycle and a compare cycle. A word equal to the pattern advances both the address and the pattern.
- R6: Each write is a three-clock sequence. In the first clock, address and data are set with `sramWeN` high. In the second, `sramWeN` is low. In the third, `sramWeN` is high again. Address and data do not change across the three clocks, and each address gets exactly one strobe per pass.
- R7: After the last address verifies correctly, the tester returns to the write phase at address 0. The write-then-verify loop repeats with no limit.
- R8: A mismatch in the compare cycle enters a halt state. In that state `errFlag`=1, the address freezes at the failing word, `sramWeN` and `sramOeN` stay 1, and no further write reaches the SRAM. The state is left only by reset.
- R9: `sramOeN` is low only in the read phase, and never at the same time as `sramWeN`. `readPhase` equals the inverse of `sramOeN`. The tester drives the data bus only while `sramOeN` is high.
- R10: With `runEn`=0, the tester holds its state. Each rising edge of `stepBtn` advances it by exactly one clock, however long the button is held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| runEn | input | 1 | 1 = advance every clock, 0 = single-step |
| stepBtn | input | 1 | Synchronous step request; each rising edge gives one clock of progress |
| sramAddr | output | ADDR_W | SRAM address |
| sramData | inout | DATA_W | Shared SRAM data bus |
| sramCeN | output | 1 | SRAM chip enable, active low |
| sramWeN | output | 1 | SRAM write strobe, active low |
| sramOeN | output | 1 | SRAM output enable, active low |
| errFlag | output | 1 | Halted on a mismatch |
| readPhase | output | 1 | Read phase in progress |

## Verification
The bench builds the tester with ADDR_W=4 and the default 8-bit pattern. A whole write pass then takes 48 clocks and a read pass takes 32, so the bench can cover several complete loops, the terminal-count wraparound and the return to the seed. At this size a word can also be corrupted in the bench memory model between the two phases, and the halt address can be predicted. With the default pattern width the bench checks the stored values against the full polynomial.

// File: rtl/sram_tester_pkg.sv
package sram_tester_pkg;

  typedef enum logic [2:0] {
    ST_WR_SET   = 3'd0,
    ST_WR_PULSE = 3'd1,
    ST_WR_HOLD  = 3'd2,
    ST_RD_ADDR  = 3'd3,
    ST_RD_CMP   = 3'd4,
    ST_HALT     = 3'd5
  } testState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clr;   // restart address counter and pattern
    logic adv;   // step address counter and pattern
  } dpStrobe_t;

endpackage

// File: rtl/sram_tester_lfsr.sv
module sram_tester_lfsr #(
  parameter int unsigned          WIDTH    = 8,
  parameter logic [WIDTH-1:0]     TAP_MASK = 8'hB8,
  parameter logic [WIDTH-1:0]     SEED     = 8'h01
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cen,
  input  logic             clr,
  input  logic             adv,
  output logic [WIDTH-1:0] value
);

  logic [WIDTH-1:0] nextValue;

  // Galois form: shift right, fold the tap mask when a one drops out
  always_comb begin
    nextValue = value >> 1;
    if (value[0]) nextValue = nextValue ^ TAP_MASK;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              value <= SEED;
    else if (cen && clr)    value <= SEED;
    else if (cen && adv)    value <= nextValue;
  end

endmodule

// File: rtl/sram_tester_counter.sv
module sram_tester_counter #(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cen,
  input  logic             clr,
  input  logic             adv,
  output logic [WIDTH-1:0] count,
  output logic             terminal
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              count <= '0;
    else if (cen && clr)    count <= '0;
    else if (cen && adv)    count <= count + 1'b1;
  end

  assign terminal = &count;

endmodule

// File: rtl/sram_tester_datapath.sv
module sram_tester_datapath
  import sram_tester_pkg::*;
#(
  parameter int unsigned        ADDR_W   = 16,
  parameter int unsigned        DATA_W   = 8,
  parameter logic [DATA_W-1:0]  TAP_MASK = 8'hB8,
  parameter logic [DATA_W-1:0]  SEED     = 8'h01
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cen,
  input  dpStrobe_t         strobe,
  input  logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] pattern,
  output logic              lastAddr,
  output logic              wordMatch
);

  sram_tester_counter #(.WIDTH(ADDR_W)) uCounter (
    .clk      (clk),
    .rstN     (rstN),
    .cen      (cen),
    .clr      (strobe.clr),
    .adv      (strobe.adv),
    .count    (addr),
    .terminal (lastAddr)
  );

  sram_tester_lfsr #(.WIDTH(DATA_W), .TAP_MASK(TAP_MASK), .SEED(SEED)) uLfsr (
    .clk   (clk),
    .rstN  (rstN),
    .cen   (cen),
    .clr   (strobe.clr),
    .adv   (strobe.adv),
    .value (pattern)
  );

  assign wordMatch = (rdData == pattern);

  assert_adv_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    (cen && strobe.adv && !strobe.clr) |=> (addr == ADDR_W'($past(addr) + 1'b1)));

  assert_clr_seed_R4: assert property (@(posedge clk) disable iff (!rstN)
    (cen && strobe.clr) |=> (addr == '0 && pattern == SEED));

endmodule

// File: rtl/sram_tester_ctrl.sv
module sram_tester_ctrl
  import sram_tester_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      runEn,
  input  logic      stepBtn,
  input  logic      lastAddr,
  input  logic      wordMatch,
  output logic      cen,
  output dpStrobe_t strobe,
  output logic      ceN,
  output logic      weN,
  output logic      oeN,
  output logic      driveEn,
  output logic      halted,
  output logic      reading
);

  testState_t state, nextState;
  logic       stepQ;

  // step edge detector runs on every clock, only the FSM is gated
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stepQ <= 1'b0;
    else       stepQ <= stepBtn;
  end

  assign cen = runEn | (stepBtn & ~stepQ);

  always_comb begin
    nextState = state;
    strobe    = '0;
    unique case (state)
      ST_WR_SET:   nextState = ST_WR_PULSE;
      ST_WR_PULSE: nextState = ST_WR_HOLD;
      ST_WR_HOLD: begin
        if (lastAddr) begin
          strobe.clr = 1'b1;
          nextState  = ST_RD_ADDR;
        end else begin
          strobe.adv = 1'b1;
          nextState  = ST_WR_SET;
        end
      end
      ST_RD_ADDR:  nextState = ST_RD_CMP;
      ST_RD_CMP: begin
        if (!wordMatch) begin
          nextState = ST_HALT;
        end else if (lastAddr) begin
          strobe.clr = 1'b1;
          nextState  = ST_WR_SET;
        end else begin
          strobe.adv = 1'b1;
          nextState  = ST_RD_ADDR;
        end
      end
      ST_HALT:     nextState = ST_HALT;
      default:     nextState = ST_HALT;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)    state <= ST_WR_SET;
    else if (cen) state <= nextState;
  end

  assign reading = (state == ST_RD_ADDR) || (state == ST_RD_CMP);
  assign halted  = (state == ST_HALT);
  assign weN     = (state != ST_WR_PULSE);
  assign oeN     = ~reading;
  assign ceN     = halted;
  assign driveEn = ~reading;

  assert_idle_freeze_R10: assert property (@(posedge clk) disable iff (!rstN)
    !cen |=> $stable(state));

  assert_halt_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_HALT) |=> (state == ST_HALT));

  assert_strobe_order_R6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(weN) |-> ($past(state) == ST_WR_SET));

endmodule

// File: rtl/sram_pattern_tester.sv
module sram_pattern_tester
  import sram_tester_pkg::*;
#(
  parameter int unsigned        ADDR_W   = 16,
  parameter int unsigned        DATA_W   = 8,
  parameter logic [DATA_W-1:0]  TAP_MASK = 8'hB8,
  parameter logic [DATA_W-1:0]  SEED     = 8'h01
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              runEn,
  input  logic              stepBtn,
  output logic [ADDR_W-1:0] sramAddr,
  inout  wire  [DATA_W-1:0] sramData,
  output logic              sramCeN,
  output logic              sramWeN,
  output logic              sramOeN,
  output logic              errFlag,
  output logic              readPhase
);

  logic              cen;
  logic              lastAddr;
  logic              wordMatch;
  logic              driveEn;
  logic [DATA_W-1:0] pattern;
  dpStrobe_t         strobe;

  sram_tester_ctrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .runEn     (runEn),
    .stepBtn   (stepBtn),
    .lastAddr  (lastAddr),
    .wordMatch (wordMatch),
    .cen       (cen),
    .strobe    (strobe),
    .ceN       (sramCeN),
    .weN       (sramWeN),
    .oeN       (sramOeN),
    .driveEn   (driveEn),
    .halted    (errFlag),
    .reading   (readPhase)
  );

  sram_tester_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TAP_MASK(TAP_MASK), .SEED(SEED)
  ) uDatapath (
    .clk       (clk),
    .rstN      (rstN),
    .cen       (cen),
    .strobe    (strobe),
    .rdData    (sramData),
    .addr      (sramAddr),
    .pattern   (pattern),
    .lastAddr  (lastAddr),
    .wordMatch (wordMatch)
  );

  assign sramData = driveEn ? pattern : 'z;

  assert_no_oe_we_overlap_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(!sramOeN && !sramWeN));

  assert_wr_setup_R6: assert property (@(posedge clk) disable iff (!rstN)
    !sramWeN |-> ($stable(sramAddr) && $stable(pattern)));

  assert_halt_freeze_R8: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |=> (errFlag && $stable(sramAddr) && sramWeN && sramOeN));

  assert_rd_entry_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(readPhase) |-> (sramAddr == '0 && pattern == SEED));

endmodule

// File: tb/tb_sram_pattern_tester.sv
module tb_sram_pattern_tester;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          runEn = 1'b1;
  logic          stepBtn = 1'b0;
  logic [AW-1:0] sramAddr;
  wire  [DW-1:0] sramData;
  logic          sramCeN, sramWeN, sramOeN, errFlag, readPhase;

  logic [DW-1:0] mem [DEPTH];
  int            nChecks = 0;
  int            nFails = 0;
  int            weFalls = 0;
  bit            done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sram_pattern_tester #(.ADDR_W(AW), .DATA_W(DW)) dut (
    .clk(clk), .rstN(rstN), .runEn(runEn), .stepBtn(stepBtn),
    .sramAddr(sramAddr), .sramData(sramData),
    .sramCeN(sramCeN), .sramWeN(sramWeN), .sramOeN(sramOeN),
    .errFlag(errFlag), .readPhase(readPhase)
  );

  // asynchronous SRAM model
  assign sramData = (rstN && !sramCeN && !sramOeN && sramWeN) ? mem[sramAddr] : 'z;

  always @(posedge sramWeN) begin
    if (rstN && !sramCeN) mem[sramAddr] <= sramData;
  end

  always @(negedge sramWeN) begin
    if (rstN) weFalls <= weFalls + 1;
  end

  function automatic logic [DW-1:0] nextPat(input logic [DW-1:0] x);
    return (x >> 1) ^ (x[0] ? 8'hB8 : 8'h00);
  endfunction

  function automatic logic [DW-1:0] patAt(input int idx);
    logic [DW-1:0] p = 8'h01;
    for (int i = 0; i < idx; i++) p = nextPat(p);
    return p;
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic doReset(input logic run);
    @(negedge clk);
    rstN = 1'b0;
    runEn = run;
    stepBtn = 1'b0;
    for (int i = 0; i < DEPTH; i++) mem[i] = 8'h00;
    tick(3);
    rstN = 1'b1;
  endtask

  task automatic pressStep();
    stepBtn = 1'b1;
    tick(3);
    stepBtn = 1'b0;
    tick(2);
  endtask

  task automatic t_reset();
    doReset(1'b1);
    check("R1", "addr", 32'(sramAddr), 0);
    check("R1", "bus", 32'(sramData), 32'h01);
    check("R1", "we/oe/ce", {29'd0, sramWeN, sramOeN, sramCeN}, 32'b110);
    check("R1", "err/read", {30'd0, errFlag, readPhase}, 0);
  endtask

  task automatic t_write_pass();
    doReset(1'b1);
    weFalls = 0;
    tick(1);
    check("R6", "strobe low in clock 2", 32'(sramWeN), 0);
    check("R6", "addr held", 32'(sramAddr), 0);
    tick(1);
    check("R6", "strobe released", 32'(sramWeN), 1);
    tick(1);
    check("R2", "addr after one write", 32'(sramAddr), 1);
    check("R3", "second pattern", 32'(sramData), 32'hB8);
    check("R2", "first word stored", 32'(mem[0]), 32'h01);
    tick(45);
    check("R4", "read phase entered", 32'(readPhase), 1);
    check("R4", "read starts at 0", 32'(sramAddr), 0);
    check("R9", "oe low in read", 32'(sramOeN), 0);
    check("R6", "one strobe per address", 32'(weFalls), DEPTH);
    for (int i = 0; i < DEPTH; i++)
      check("R2", $sformatf("mem[%0d]", i), 32'(mem[i]), 32'(patAt(i)));
    check("R3", "third pattern", 32'(mem[2]), 32'h5C);
  endtask

  task automatic t_read_pass();
    tick(10);
    check("R5", "addr after five compares", 32'(sramAddr), 5);
    check("R5", "no error", 32'(errFlag), 0);
    tick(1);
    check("R9", "bus carries stored word", 32'(sramData), 32'(patAt(5)));
    check("R9", "readPhase mirrors oe", 32'(readPhase), 32'(!sramOeN));
    tick(21);
    check("R7", "back to write", 32'(readPhase), 0);
    check("R7", "write restarts at 0", 32'(sramAddr), 0);
    check("R7", "seed driven again", 32'(sramData), 32'h01);
  endtask

  task automatic t_endless_loop();
    tick(160);
    check("R7", "still running after two loops", 32'(errFlag), 0);
    check("R7", "at write start", {30'd0, readPhase, 1'b0} | 32'(sramAddr), 0);
    check("R7", "contents rewritten", 32'(mem[DEPTH-1]), 32'(patAt(DEPTH-1)));
  endtask

  task automatic t_fault();
    doReset(1'b1);
    tick(48);
    mem[5] = mem[5] ^ 8'h10;
    tick(11);
    check("R8", "no error before compare", 32'(errFlag), 0);
    tick(1);
    check("R8", "error raised", 32'(errFlag), 1);
    check("R8", "failing addr", 32'(sramAddr), 5);
    tick(40);
    check("R8", "addr frozen", 32'(sramAddr), 5);
    check("R8", "still halted", 32'(errFlag), 1);
    check("R8", "strobes idle", {30'd0, sramWeN, sramOeN}, 32'b11);
    check("R8", "bad word untouched", 32'(mem[5]), 32'(patAt(5) ^ 8'h10));
    check("R8", "word 0 untouched", 32'(mem[0]), 32'h01);
  endtask

  task automatic t_step();
    doReset(1'b0);
    tick(6);
    check("R10", "held without step", {31'd0, sramWeN}, 1);
    check("R10", "addr held", 32'(sramAddr), 0);
    pressStep();
    check("R10", "one step into strobe", 32'(sramWeN), 0);
    check("R10", "long press single step", 32'(sramAddr), 0);
    pressStep();
    check("R10", "second step releases", 32'(sramWeN), 1);
    pressStep();
    check("R10", "third step next addr", 32'(sramAddr), 1);
    check("R10", "word 0 written by steps", 32'(mem[0]), 32'h01);
  endtask

  initial begin
    t_reset();
    t_write_pass();
    t_read_pass();
    t_endless_loop();
    t_fault();
    t_step();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

endmodule